// File: doc/BRIEF.md
# Vector Unzip Permute Unit

This unit separates two interleaved SIMD operands into one result vector. It joins the second operand B above the first operand A to form one double-width vector. It then takes every second element of that vector, starting at element 0 or element 1. The elements picked from A fill the low half of the result and the elements picked from B fill the high half, each in ascending order. Running the operation once with even selection and once with odd selection splits a pair of interleaved vectors into their two streams.

A 2-bit size code sets the element width, and a width bit chooses a 64-bit or a 128-bit vector. One size/width combination is reserved. For it the unit raises an undefined flag and returns no data. Operands enter through a valid/ready handshake, and each result is held in one output register until the consumer takes it.

Top module: `vec_unzip_unit`

## Requirements
- R1: Size code c (in_size) gives elements of 8<<c bits, so codes 0, 1, 2 and 3 select 8, 16, 32 and 64-bit elements.
- R2: With in_wide=1 the vector is 128 bits wide and has 128/esize elements. Result element e equals element 2*e+in_part of the 256-bit value {in_b, in_a}, where in_a is the low half.
- R3: With in_part=0, the even elements of in_a fill the low half of the result in ascending order, and the even elements of in_b fill the high half.
- R4: With in_part=1, the odd elements are selected in the same arrangement.
- R5: With in_wide=0, only bits [63:0] of each operand are used. The result sits in out_data[63:0], and out_data[127:64] is zero.
- R6: in_size=3 with in_wide=0 is reserved. It produces out_undef=1 and out_data of all zeros.
- R7: out_undef is 0 for every other size/width combination.
- R8: An input is accepted on a rising edge where in_valid and in_ready are both 1. Its result appears with out_valid=1 after that edge.
- R9: in_ready equals !out_valid || out_ready. While out_valid=1 and out_ready=0, out_valid, out_data and out_undef stay unchanged and no new input is taken.
- R10: After a synchronous active-low reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands present |
| in_ready | output | 1 | Unit can take operands |
| in_a | input | 128 | First source, forms the low half of the joined vector |
| in_b | input | 128 | Second source, forms the high half of the joined vector |
| in_size | input | 2 | Element size code |
| in_wide | input | 1 | 1: 128-bit vector, 0: 64-bit vector |
| in_part | input | 1 | 0: even elements, 1: odd elements |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 128 | Unzipped result |
| out_undef | output | 1 | Reserved encoding was requested |

## Verification
A wrong lane selection or a wrong size/width decode shows up in out_data on the cycle right after the accepting edge. Each result is compared bit for bit against a reference loop that is written independently of the RTL. Operands with distinct byte indices make any swapped, shifted or duplicated element visible in one transaction. A wrong hold or ready state shows up during a stall: either the held result changes, or a second operand set replaces the first before out_ready rises.

// File: rtl/vunzip_pkg.sv
// Shared types and helpers for the vector unzip unit.
// Assumes at most four element size codes (2-bit code).
package vunzip_pkg;
    localparam int SIZE_CODE_W = 2;
    localparam int NUM_SIZES   = 1 << SIZE_CODE_W;

    typedef logic [SIZE_CODE_W-1:0] esize_code_t;

    // Reports whether a size/width pair is the reserved encoding.
    function automatic logic is_reserved(input esize_code_t code, input logic wide);
        return (code == esize_code_t'(NUM_SIZES - 1)) && !wide;
    endfunction
endpackage

// File: rtl/vunzip_permute.sv
// Fixed-element-size unzip network. It builds the wide (full VEC_W) and
// narrow (VEC_W/2) results for one element width. Assumes that ELEM_W
// divides VEC_W/2. Narrow output is zero when fewer than two narrow elements exist.
module vunzip_permute #(
    parameter int VEC_W  = 128,
    parameter int ELEM_W = 8
) (
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    input  logic             part,
    output logic [VEC_W-1:0] wide_res,
    output logic [VEC_W-1:0] narrow_res
);
    localparam int HALF_W    = VEC_W / 2;
    localparam int WIDE_CNT  = VEC_W / ELEM_W;
    localparam int NARR_CNT  = HALF_W / ELEM_W;

    // Wide variant: pick element 2e+part of A for the low half and of B for the high half.
    for (genvar e = 0; e < WIDE_CNT / 2; e++) begin : g_wide
        assign wide_res[e*ELEM_W +: ELEM_W] =
            part ? src_a[(2*e+1)*ELEM_W +: ELEM_W] : src_a[(2*e)*ELEM_W +: ELEM_W];
        assign wide_res[(e + WIDE_CNT/2)*ELEM_W +: ELEM_W] =
            part ? src_b[(2*e+1)*ELEM_W +: ELEM_W] : src_b[(2*e)*ELEM_W +: ELEM_W];
    end

    // Narrow variant: same rule on the low halves, upper half forced to zero.
    if (NARR_CNT >= 2) begin : g_narrow
        for (genvar e = 0; e < NARR_CNT / 2; e++) begin : g_lane
            assign narrow_res[e*ELEM_W +: ELEM_W] =
                part ? src_a[(2*e+1)*ELEM_W +: ELEM_W] : src_a[(2*e)*ELEM_W +: ELEM_W];
            assign narrow_res[(e + NARR_CNT/2)*ELEM_W +: ELEM_W] =
                part ? src_b[(2*e+1)*ELEM_W +: ELEM_W] : src_b[(2*e)*ELEM_W +: ELEM_W];
        end
        assign narrow_res[VEC_W-1:HALF_W] = '0;
    end else begin : g_no_narrow
        assign narrow_res = '0;
    end
endmodule

// File: rtl/vunzip_select.sv
// Chooses among the per-size results by size code and width, and applies
// the reserved-encoding rule. Purely combinational.
module vunzip_select
    import vunzip_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic [NUM_SIZES-1:0][VEC_W-1:0] wide_set,
    input  logic [NUM_SIZES-1:0][VEC_W-1:0] narrow_set,
    input  esize_code_t                     size_code,
    input  logic                            wide,
    output logic [VEC_W-1:0]                res_data,
    output logic                            res_undef
);
    // Pick the permuted vector, or zero it for the reserved encoding.
    always_comb begin
        res_undef = is_reserved(size_code, wide);
        if (res_undef)
            res_data = '0;
        else if (wide)
            res_data = wide_set[size_code];
        else
            res_data = narrow_set[size_code];
    end
endmodule

// File: rtl/vunzip_out_stage.sv
// One-entry output register with a valid/ready handshake. It accepts when
// empty or when draining in the same cycle, and holds the payload while stalled.
module vunzip_out_stage #(
    parameter int DATA_W = 129
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_payload,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_payload
);
    assign in_ready = !out_valid || out_ready;

    // Capture on accept, clear valid when drained with nothing new.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_payload <= '0;
        end else if (in_valid && in_ready) begin
            out_valid   <= 1'b1;
            out_payload <= in_payload;
        end else if (out_ready) begin
            out_valid   <= 1'b0;
        end
    end

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_payload)); // R9
    AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid); // R8
endmodule

// File: rtl/vec_unzip_unit.sv
// Top of the vector unzip unit. One permute network per element size,
// a size/width selector and a registered output stage.
// Assumes VEC_W is a multiple of 128 so that every size fits both widths.
module vec_unzip_unit
    import vunzip_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [VEC_W-1:0] in_a,
    input  logic [VEC_W-1:0] in_b,
    input  logic [1:0]       in_size,
    input  logic             in_wide,
    input  logic             in_part,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [VEC_W-1:0] out_data,
    output logic             out_undef
);
    localparam int PAY_W = VEC_W + 1;

    logic [NUM_SIZES-1:0][VEC_W-1:0] wide_set;
    logic [NUM_SIZES-1:0][VEC_W-1:0] narrow_set;
    logic [VEC_W-1:0]                sel_data;
    logic                            sel_undef;
    logic [PAY_W-1:0]                pay_q;

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
        vunzip_permute #(.VEC_W(VEC_W), .ELEM_W(8 << s)) u_perm (
            .src_a      (in_a),
            .src_b      (in_b),
            .part       (in_part),
            .wide_res   (wide_set[s]),
            .narrow_res (narrow_set[s])
        );
    end

    vunzip_select #(.VEC_W(VEC_W)) u_sel (
        .wide_set   (wide_set),
        .narrow_set (narrow_set),
        .size_code  (in_size),
        .wide       (in_wide),
        .res_data   (sel_data),
        .res_undef  (sel_undef)
    );

    vunzip_out_stage #(.DATA_W(PAY_W)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_payload  ({sel_undef, sel_data}),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_payload (pay_q)
    );

    assign out_data  = pay_q[VEC_W-1:0];
    assign out_undef = pay_q[VEC_W];

    AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_undef |-> out_data == '0); // R6
    AST_RESERVED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_size == 2'd3 && !in_wide |=> out_undef); // R6
    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !in_wide |=> out_data[VEC_W-1:VEC_W/2] == '0); // R5
    AST_RESET_EMPTY: assert property (@(posedge clk)
        !rst_n |=> !out_valid); // R10
endmodule

// File: tb/sim_vec_unzip_unit.sv
module sim_vec_unzip_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] in_a = '0;
    logic [127:0] in_b = '0;
    logic [1:0]   in_size = '0;
    logic         in_wide = 1'b0;
    logic         in_part = 1'b0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [127:0] out_data;
    logic         out_undef;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    vec_unzip_unit u0 (.*);

    // Reference unzip written as a plain element loop.
    function automatic logic [127:0] ref_unzip(input logic [127:0] a, input logic [127:0] b,
                                               input logic [1:0] sz, input logic wide,
                                               input logic part);
        logic [255:0] z;
        logic [127:0] r;
        int es, w, n;
        r = '0;
        if (sz == 2'd3 && !wide) return r;
        es = 8 << sz;
        w  = wide ? 128 : 64;
        n  = w / es;
        z  = wide ? {b, a} : {128'b0, b[63:0], a[63:0]};
        for (int e = 0; e < n; e++)
            for (int k = 0; k < es; k++)
                r[e*es + k] = z[(2*e + part)*es + k];
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Sends one transaction with out_ready high and checks the result.
    task automatic send(input logic [127:0] a, input logic [127:0] b, input logic [1:0] sz,
                        input logic wide, input logic part, input string req);
        logic [127:0] exp;
        logic         exp_u;
        exp   = ref_unzip(a, b, sz, wide, part);
        exp_u = (sz == 2'd3) && !wide;
        @(negedge clk);
        in_a = a; in_b = b; in_size = sz; in_wide = wide; in_part = part;
        in_valid = 1'b1; out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid === 1'b1, "R8", {127'b0, out_valid}, 128'd1);
        chk(out_undef === exp_u, exp_u ? "R6" : "R7", {127'b0, out_undef}, {127'b0, exp_u});
        chk(out_data === exp, req, out_data, exp);
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        logic [127:0] pa, pb, x1a, x1b, x2a, x2b, e1, e2;
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid === 1'b0, "R10", {127'b0, out_valid}, 128'd0);
        chk(in_ready === 1'b1, "R10", {127'b0, in_ready}, 128'd1);

        // Directed index patterns: byte i of A = i, byte i of B = 0x80+i.
        for (int i = 0; i < 16; i++) begin
            pa[i*8 +: 8] = 8'(i);
            pb[i*8 +: 8] = 8'(8'h80 + i);
        end
        for (int s = 0; s < 4; s++)
            for (int w = 0; w < 2; w++)
                for (int p = 0; p < 2; p++)
                    send(pa, pb, 2'(s), w[0], p[0],
                         (s == 3 && w == 0) ? "R6" :
                         (w == 0) ? "R5" : (p == 0) ? "R3" : "R4");

        // Hand-computed case: 16-bit elements, 128 bits wide, even selection gives R1 R2 element order.
        send(pa, pb, 2'd1, 1'b1, 1'b0, "R1");
        chk(out_data[15:0] === 16'h0100 && out_data[127:112] === 16'h8d8c, "R2",
            out_data, 128'h8d8c_0000_0000_0000_0000_0000_0000_0100);

        // Constrained random over every combination.
        for (int t = 0; t < 400; t++)
            send(rnd128(), rnd128(), 2'($urandom % 4), 1'($urandom), 1'($urandom), "R2");

        // Stall: the result must hold and a second operand set must wait.
        x1a = rnd128(); x1b = rnd128(); x2a = rnd128(); x2b = rnd128();
        e1 = ref_unzip(x1a, x1b, 2'd0, 1'b1, 1'b1);
        e2 = ref_unzip(x2a, x2b, 2'd2, 1'b0, 1'b0);
        @(negedge clk);
        in_a = x1a; in_b = x1b; in_size = 2'd0; in_wide = 1'b1; in_part = 1'b1;
        in_valid = 1'b1; out_ready = 1'b0;
        @(negedge clk);
        in_a = x2a; in_b = x2b; in_size = 2'd2; in_wide = 1'b0; in_part = 1'b0;
        chk(in_ready === 1'b0, "R9", {127'b0, in_ready}, 128'd0);
        chk(out_data === e1, "R9", out_data, e1);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk(out_valid === 1'b1 && out_data === e1, "R9", out_data, e1);
        end
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid === 1'b1 && out_data === e2, "R8", out_data, e2);
        @(negedge clk);
        chk(out_valid === 1'b0, "R9", {127'b0, out_valid}, 128'd0);

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule